// File: doc/BRIEF.md
# Shadowed Nonvolatile Static Memory

This block models a byte-wide static memory in which every word has a nonvolatile shadow copy. The SRAM array and the shadow array are separate storage arrays. A host reaches the SRAM through an asynchronous-style port with active-low chip select, output enable and write strobe. A fourth active-low control, the nonvolatile select, changes the meaning of that port from ordinary access to bulk transfer requests. A save copies the whole SRAM into the shadow. A restore first clears the SRAM and then copies the shadow back into it. A restore also runs on its own every time reset is released.

Transfers are sequenced by a clocked state machine that moves one word per clock. While a transfer runs, the block raises `busy`, and every host read, write and new transfer request is locked out. The address width is a parameter. The full device uses `ADDR_W = 13` (8192 words), and the default is 11 to keep elaboration small.

Top module: `nvsram_shadow`

## Requirements
- R1: Releasing reset starts a restore. `busy` is high during reset and falls exactly 2·2^ADDR_W rising clock edges after reset is released.
- R2: When `ce_n` and `oe_n` are low, `we_n` and `nv_n` are high and `busy` is low, `dout_oe` is 1 and `dout` shows the SRAM word at `addr`.
- R3: With `nv_n` high and `ce_n` low, a low-to-high transition of `we_n` seen at a clock edge writes `din` into the SRAM word at `addr`, using the values present at that edge.
- R4: `dout_oe` is 0 whenever `busy`, `oe_n` or `ce_n` is high.
- R5: When `nv_n`, `ce_n` and `we_n` become low together, a save starts. `busy` rises at that edge and falls 2^ADDR_W edges later, and every SRAM word is then held in the shadow.
- R6: While `busy` is high, new save or restore requests are ignored and SRAM write strobes have no effect. A request still held when the transfer finishes does not start a new one.
- R7: When `nv_n`, `ce_n` and `oe_n` are low with `we_n` high, a restore starts. It clears every SRAM word, then copies every shadow word into the SRAM, taking 2·2^ADDR_W edges.
- R8: A restore leaves the shadow unchanged, so repeated restores give the same SRAM contents.
- R9: The write strobe that starts a save, given while `nv_n` is low, does not write the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock |
| rst_n | input | 1 | Active-low asynchronous reset, release triggers restore |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Data driver enable, 0 means high impedance |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| nv_n | input | 1 | Nonvolatile transfer select, active low |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is host activity that arrives in the middle of a save. This covers a restore request, a complete write strobe with `nv_n` back high, and a read attempt, all made while `busy` is high. The bench reaches it by changing the control pins partway through the save's word count. It then confirms that the save length did not change, that the strobed word still holds its old value, and that the driver stayed off. The clear phase of a restore cannot be seen at the ports, so the bench shows its effect instead: words overwritten after a save return to their saved values after one restore and again after a second one.

// File: rtl/nvsram_shadow.sv
module nvsram_shadow #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nv_n,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_RCLR, S_RCOPY} st_t;

  st_t               state;
  logic [ADDR_W-1:0] cnt;
  logic              we_q, st_q, rc_q;
  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  logic              store_req, recall_req, user_wr, sram_we;
  logic [ADDR_W-1:0] sram_wa;
  logic [DATA_W-1:0] sram_wd;

  assign store_req  = ~nv_n & ~ce_n & ~we_n;
  assign recall_req = ~nv_n & ~ce_n & ~oe_n & we_n;
  assign busy       = (state != S_IDLE);
  assign user_wr    = ~busy & nv_n & ~ce_n & we_n & ~we_q;
  assign sram_we    = user_wr | (state == S_RCLR) | (state == S_RCOPY);
  assign sram_wa    = busy ? cnt : addr;
  assign sram_wd    = (state == S_RCOPY) ? shadow[cnt] :
                      (state == S_RCLR)  ? '0 : din;

  assign dout_oe = ~busy & nv_n & ~ce_n & ~oe_n & we_n;
  assign dout    = sram[addr];

  always_ff @(posedge clk) begin
    if (sram_we) sram[sram_wa] <= sram_wd;
    if (state == S_STORE) shadow[cnt] <= sram[cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RCLR;
      cnt   <= '0;
      we_q  <= 1'b1;
      st_q  <= 1'b0;
      rc_q  <= 1'b0;
    end else begin
      we_q <= we_n;
      st_q <= store_req;
      rc_q <= recall_req;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (store_req && !st_q)       state <= S_STORE;
          else if (recall_req && !rc_q) state <= S_RCLR;
        end
        S_STORE: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_IDLE;
        end
        S_RCLR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_RCOPY;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_IDLE;
        end
      endcase
    end
  end

  assert_no_drive_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_oe);

  assert_copy_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RCOPY) |-> ($past(state) == S_RCLR || $past(state) == S_RCOPY));

  assert_store_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE && cnt != LAST) |=> (state == S_STORE && cnt == $past(cnt) + 1'b1));

  assert_store_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE && cnt == LAST) |=> !busy);

  assert_idle_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(store_req) || $past(recall_req)));
endmodule

// File: tb/nvsram_shadow_bench.sv
module nvsram_shadow_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_oe;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
  logic          busy;

  int checks = 0;
  int errors = 0;

  logic [7:0] ref_sram   [N];
  logic [7:0] ref_shadow [N];

  typedef struct {
    int         a;
    logic [7:0] d;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  event samp;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_shadow #(.ADDR_W(AW), .DATA_W(8)) u_nvsram_shadow (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .nv_n(nv_n), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always begin
    @(samp);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " oe"}, int'(dout_oe), 1);
      check({e.tag, " data"}, int'(dout), int'(e.d));
    end
  end

  task automatic rd(input int a, input string tag);
    exp_t e;
    @(negedge clk); addr = AW'(a); nv_n = 1; we_n = 1; ce_n = 0; oe_n = 0;
    @(negedge clk);
    e.a = a; e.d = ref_sram[a]; e.tag = tag;
    exp_q.push_back(e);
    -> samp;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = AW'(a); din = d; nv_n = 1; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    ref_sram[a] = d;
  endtask

  task automatic count_busy(output int n, input bit inject, input int b, input logic [7:0] z);
    n = 0;
    for (int i = 0; i < 4 * N; i++) begin
      @(posedge clk); #1;
      n++;
      if (inject && n == N/4) begin oe_n = 0; we_n = 1; end
      if (inject && n == N/4 + 2) begin nv_n = 1; addr = AW'(b); din = z; oe_n = 1; we_n = 0; end
      if (inject && n == N/4 + 4) begin we_n = 1; oe_n = 0; end
      if (inject && n == N/4 + 5) check("R4 read while busy", int'(dout_oe), 0);
      if (!busy) break;
    end
  endtask

  task automatic do_store(input int a, input logic [7:0] d, input bit inject, input int b, input logic [7:0] z);
    int n;
    @(negedge clk); addr = AW'(a); din = d; oe_n = 1; nv_n = 0; ce_n = 0; we_n = 0;
    @(posedge clk); #1;
    check("R5 busy at start", int'(busy), 1);
    count_busy(n, inject, b, z);
    check("R5 save length", n, N);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1; nv_n = 1;
    @(posedge clk); #1;
    check("R6 no restart", int'(busy), 0);
    for (int i = 0; i < N; i++) ref_shadow[i] = ref_sram[i];
  endtask

  task automatic do_recall();
    int n;
    @(negedge clk); we_n = 1; nv_n = 0; ce_n = 0; oe_n = 0;
    @(posedge clk); #1;
    check("R7 busy at start", int'(busy), 1);
    count_busy(n, 1'b0, 0, 8'h00);
    check("R7 restore length", n, 2 * N);
    @(negedge clk); ce_n = 1; oe_n = 1; nv_n = 1;
    for (int i = 0; i < N; i++) ref_sram[i] = ref_shadow[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 1);
    check("R4 oe in reset", int'(dout_oe), 0);
    rst_n = 1;
    count_busy(n, 1'b0, 0, 8'h00);
    check("R1 power-up restore length", n, 2 * N);

    for (int a = 0; a < N; a++) wr(a, 8'((a * 37 + 11) & 8'hFF));
    rd(0, "R3 word 0");
    rd(N - 1, "R3 last word");
    rd(300, "R2 mid word");

    @(negedge clk); addr = AW'(5); nv_n = 1; we_n = 1; ce_n = 0; oe_n = 1;
    @(negedge clk); check("R4 oe_n high", int'(dout_oe), 0);
    ce_n = 1; oe_n = 0;
    @(negedge clk); check("R4 ce_n high", int'(dout_oe), 0);
    oe_n = 1;

    do_store(17, 8'hE1, 1'b1, 40, 8'h5A);
    rd(17, "R9 save strobe no write");
    rd(40, "R6 write during busy ignored");

    wr(17, 8'h00); wr(40, 8'hC3); wr(N - 1, 8'h99); wr(1, 8'h42);
    rd(40, "R3 overwrite");
    do_recall();
    rd(17, "R7 restored word 17");
    rd(40, "R7 restored word 40");
    rd(N - 1, "R7 restored last");
    rd(1, "R7 restored word 1");

    wr(1, 8'hAA); wr(999, 8'h0F);
    do_recall();
    rd(1, "R8 repeat restore word 1");
    rd(999, "R8 repeat restore word 999");
    rd(17, "R8 repeat restore word 17");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule